// File: doc/BRIEF.md
# Multi-Channel Priority Request Arbiter

This block sits between a set of requesting ports and a small number of memory channels. One client may own several ports. Every clock cycle it looks at the ports that are requesting. It then grants up to one request per channel, and the winners are the requesting ports that rank highest in a priority ordering that software can program. A port that is not granted keeps its request raised and competes again in the next cycle. Each winner is issued on a channel together with its port number and payload, and channel 0 always carries the best-ranked winner.

The ordering is a register that holds one port number per slot. Slot 0 is the highest priority. Software replaces the whole ordering in a single load, and the block refuses any load that is not a permutation of the port numbers. A rotate command moves the port in the lowest slot to slot 0 and pushes every other port down one slot, which gives round-robin service when it is issued repeatedly. Results come back on the channels tagged with the port number, and the block steers each result to that port's response outputs. Address translation and the memories themselves are outside this block.

Top module: `prio_channel_arbiter`

## Requirements
- R1: After reset, `req_grant`, `ch_valid` and `rsp_valid` are all zero, and `prio_order` holds port k in slot k. Slot k occupies bits [k*ID_W +: ID_W], and slot 0 is the highest priority.
- R2: Requests are sampled at a clock edge, and the grants appear on the outputs right after that same edge, so the latency is one cycle. The arbiter grants at most NUM_CH ports per cycle. The granted ports are the requesting ports whose slots rank highest. When NUM_CH or more ports request, every channel is used.
- R3: Channel c carries the winner of rank c: `ch_port` holds its port number and `ch_payload` holds its payload. Valid channels always form a run that starts at channel 0 and has no gaps.
- R4: `req_grant[p]` is high for exactly one cycle for each granted request. A requesting port that loses keeps its request raised and receives no grant in that cycle. When fewer ports request than there are channels, every requesting port is granted.
- R5: Raising `cfg_load` with a `cfg_order` that is a permutation of the port numbers replaces the ordering, and the new ordering shows on `prio_order` after that edge. The arbitration at that same edge still uses the old ordering.
- R6: A `cfg_load` whose `cfg_order` repeats any port number is ignored, and `prio_order` stays unchanged.
- R7: When `cfg_rotate` is raised without `cfg_load`, the new slot 0 takes the old lowest slot and the new slot k takes the old slot k-1.
- R8: When `cfg_load` and `cfg_rotate` are raised in the same cycle, the rotate is dropped, whether or not the load is accepted.
- R9: A result on channel c (`ch_rsp_valid[c]`, `ch_rsp_port`, `ch_rsp_data`) appears one cycle later on `rsp_valid[port]` and `rsp_data[port]`. If two channels name the same port in the same cycle, the lower channel's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request raised by each port |
| req_payload | input | NUM_PORTS*PAY_W | Payload of each port; port p at [p*PAY_W +: PAY_W] |
| req_grant | output | NUM_PORTS | One-cycle grant to each port |
| ch_valid | output | NUM_CH | Channel carries an access this cycle |
| ch_port | output | NUM_CH*ID_W | Granted port number for each channel |
| ch_payload | output | NUM_CH*PAY_W | Granted payload for each channel |
| ch_rsp_valid | input | NUM_CH | Result returning on each channel |
| ch_rsp_port | input | NUM_CH*ID_W | Port that each result belongs to |
| ch_rsp_data | input | NUM_CH*RSP_W | Result data for each channel |
| rsp_valid | output | NUM_PORTS | Result delivered to each port |
| rsp_data | output | NUM_PORTS*RSP_W | Result data for each port |
| cfg_load | input | 1 | Load a new priority ordering |
| cfg_order | input | NUM_PORTS*ID_W | Ordering to load, slot k at [k*ID_W +: ID_W] |
| cfg_rotate | input | 1 | Rotate the ordering by one slot |
| prio_order | output | NUM_PORTS*ID_W | Current ordering, slot 0 highest |

## Verification
The bench puts more requesters into contention than there are channels and keeps every loser's request raised. A design that lost or repeated a winner, or that placed the second-best winner on channel 0, would show a grant vector or channel assignment that differs from the bench model. Orderings are reloaded, reloaded with a repeated port number, rotated, and loaded and rotated in the same cycle. A table that accepted a bad load, rotated in the wrong direction, or let a rotate slip past a load would drift away from the modelled ordering. The bench also checks that a new ordering takes effect one cycle late, and it makes two channels return results to the same port so that the wrong channel winning is caught.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    TBL_HOLD   = 2'd0,
    TBL_LOAD   = 2'd1,
    TBL_ROTATE = 2'd2
  } tbl_action_e;
endpackage

// File: rtl/arb_prio_table.sv
module arb_prio_table
  import arb_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ID_W      = $clog2(NUM_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_en,
  input  logic [NUM_PORTS*ID_W-1:0] load_order,
  input  logic                      rotate_en,
  output logic [NUM_PORTS*ID_W-1:0] order
);
  localparam int TW = NUM_PORTS * ID_W;

  logic [NUM_PORTS-1:0] seen;
  logic                 load_ok;
  tbl_action_e          action;

  // a load is a permutation when every port number shows up at least once
  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_PORTS; k++) seen[load_order[k*ID_W +: ID_W]] = 1'b1;
    load_ok = &seen;
  end

  always_comb begin
    if (load_en) action = load_ok ? TBL_LOAD : TBL_HOLD;
    else if (rotate_en) action = TBL_ROTATE;
    else action = TBL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_PORTS; k++) order[k*ID_W +: ID_W] <= ID_W'(k);
    end else begin
      case (action)
        TBL_LOAD:   order <= load_order;
        TBL_ROTATE: order <= {order[TW-ID_W-1:0], order[TW-1 -: ID_W]};
        default:    order <= order;
      endcase
    end
  end

  // checker-side view: how many slots hold each port number
  logic [NUM_PORTS-1:0] id_once;
  always_comb begin
    for (int id = 0; id < NUM_PORTS; id++) begin
      int hits;
      hits = 0;
      for (int k = 0; k < NUM_PORTS; k++)
        if (int'(order[k*ID_W +: ID_W]) == id) hits++;
      id_once[id] = (hits == 1);
    end
  end

  AST_TABLE_IS_PERM: assert property (@(posedge clk) disable iff (rst)
    &id_once); // R5
  AST_BAD_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    load_en && !load_ok |=> $stable(order)); // R6
  AST_ROTATE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    rotate_en && !load_en |=> order[ID_W-1:0] == $past(order[TW-1 -: ID_W])); // R7
  AST_LOAD_BEATS_ROTATE: assert property (@(posedge clk) disable iff (rst)
    load_en && rotate_en |=> (order == $past(load_order)) || $stable(order)); // R8
endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CH    = 2,
  parameter int ID_W      = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0]      req,
  input  logic [NUM_PORTS*ID_W-1:0] order,
  output logic [NUM_CH-1:0]         win_valid,
  output logic [NUM_CH*ID_W-1:0]    win_port,
  output logic [NUM_PORTS-1:0]      win_mask
);
  // walk the slots from highest priority, handing winners to channels in rank order
  always_comb begin
    int taken;
    logic [ID_W-1:0] p;
    taken     = 0;
    win_valid = '0;
    win_port  = '0;
    win_mask  = '0;
    for (int s = 0; s < NUM_PORTS; s++) begin
      p = order[s*ID_W +: ID_W];
      if (req[p] && taken < NUM_CH) begin
        win_valid[taken]              = 1'b1;
        win_port[taken*ID_W +: ID_W]  = p;
        win_mask[p]                   = 1'b1;
        taken++;
      end
    end
  end
endmodule

// File: rtl/arb_rsp_router.sv
module arb_rsp_router #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CH    = 2,
  parameter int RSP_W     = 16,
  parameter int ID_W      = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          ch_rsp_valid,
  input  logic [NUM_CH*ID_W-1:0]     ch_rsp_port,
  input  logic [NUM_CH*RSP_W-1:0]    ch_rsp_data,
  output logic [NUM_PORTS-1:0]       rsp_valid,
  output logic [NUM_PORTS*RSP_W-1:0] rsp_data
);
  logic [NUM_PORTS-1:0]       v_n;
  logic [NUM_PORTS*RSP_W-1:0] d_n;

  // highest channel first so that a lower channel overwrites on a clash
  always_comb begin
    v_n = '0;
    d_n = rsp_data;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (ch_rsp_valid[c]) begin
        v_n[ch_rsp_port[c*ID_W +: ID_W]] = 1'b1;
        d_n[int'(ch_rsp_port[c*ID_W +: ID_W])*RSP_W +: RSP_W] = ch_rsp_data[c*RSP_W +: RSP_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= v_n;
      rsp_data  <= d_n;
    end
  end

  AST_RSP_NEEDS_CH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid != '0) |-> ($past(ch_rsp_valid) != '0)); // R9
  AST_RSP_CH0_ROUTED: assert property (@(posedge clk) disable iff (rst)
    ch_rsp_valid[0] |=> rsp_valid[$past(ch_rsp_port[ID_W-1:0])]); // R9
endmodule

// File: rtl/prio_channel_arbiter.sv
module prio_channel_arbiter #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CH    = 2,
  parameter int PAY_W     = 16,
  parameter int RSP_W     = 16,
  parameter int ID_W      = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS-1:0]       req_valid,
  input  logic [NUM_PORTS*PAY_W-1:0] req_payload,
  output logic [NUM_PORTS-1:0]       req_grant,
  output logic [NUM_CH-1:0]          ch_valid,
  output logic [NUM_CH*ID_W-1:0]     ch_port,
  output logic [NUM_CH*PAY_W-1:0]    ch_payload,
  input  logic [NUM_CH-1:0]          ch_rsp_valid,
  input  logic [NUM_CH*ID_W-1:0]     ch_rsp_port,
  input  logic [NUM_CH*RSP_W-1:0]    ch_rsp_data,
  output logic [NUM_PORTS-1:0]       rsp_valid,
  output logic [NUM_PORTS*RSP_W-1:0] rsp_data,
  input  logic                       cfg_load,
  input  logic [NUM_PORTS*ID_W-1:0]  cfg_order,
  input  logic                       cfg_rotate,
  output logic [NUM_PORTS*ID_W-1:0]  prio_order
);
  logic [NUM_CH-1:0]       win_valid;
  logic [NUM_CH*ID_W-1:0]  win_port;
  logic [NUM_PORTS-1:0]    win_mask;
  logic [NUM_CH*PAY_W-1:0] win_payload;

  arb_prio_table #(.NUM_PORTS(NUM_PORTS), .ID_W(ID_W)) u_table (
    .clk(clk), .rst(rst), .load_en(cfg_load), .load_order(cfg_order),
    .rotate_en(cfg_rotate), .order(prio_order)
  );

  arb_select #(.NUM_PORTS(NUM_PORTS), .NUM_CH(NUM_CH), .ID_W(ID_W)) u_select (
    .req(req_valid), .order(prio_order), .win_valid(win_valid),
    .win_port(win_port), .win_mask(win_mask)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pay
      assign win_payload[c*PAY_W +: PAY_W] =
        req_payload[int'(win_port[c*ID_W +: ID_W])*PAY_W +: PAY_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      req_grant  <= '0;
      ch_valid   <= '0;
      ch_port    <= '0;
      ch_payload <= '0;
    end else begin
      req_grant  <= win_mask;
      ch_valid   <= win_valid;
      ch_port    <= win_port;
      ch_payload <= win_payload;
    end
  end

  arb_rsp_router #(.NUM_PORTS(NUM_PORTS), .NUM_CH(NUM_CH), .RSP_W(RSP_W), .ID_W(ID_W)) u_rsp (
    .clk(clk), .rst(rst), .ch_rsp_valid(ch_rsp_valid), .ch_rsp_port(ch_rsp_port),
    .ch_rsp_data(ch_rsp_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_grant & ~$past(req_valid)) == '0); // R4
  AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(req_grant) <= NUM_CH); // R2
  AST_CH_MATCH_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(ch_valid) == $countones(req_grant)); // R3
  AST_CH_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    ((ch_valid + 1'b1) & ch_valid) == '0); // R3
  AST_ALL_CH_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($countones($past(req_valid)) >= NUM_CH) |-> &ch_valid); // R2
endmodule

// File: tb/test_prio_channel_arbiter.sv
module test_prio_channel_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NC = 2;
  localparam int PW = 16;
  localparam int RW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] req_valid = '0;
  logic [NP*PW-1:0] req_payload = '0;
  logic [NP-1:0] req_grant;
  logic [NC-1:0] ch_valid;
  logic [NC*IW-1:0] ch_port;
  logic [NC*PW-1:0] ch_payload;
  logic [NC-1:0] ch_rsp_valid = '0;
  logic [NC*IW-1:0] ch_rsp_port = '0;
  logic [NC*RW-1:0] ch_rsp_data = '0;
  logic [NP-1:0] rsp_valid;
  logic [NP*RW-1:0] rsp_data;
  logic cfg_load = 1'b0;
  logic [NP*IW-1:0] cfg_order = '0;
  logic cfg_rotate = 1'b0;
  logic [NP*IW-1:0] prio_order;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_channel_arbiter #(.NUM_PORTS(NP), .NUM_CH(NC), .PAY_W(PW), .RSP_W(RW)) i_prio_channel_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_payload(req_payload), .req_grant(req_grant),
    .ch_valid(ch_valid), .ch_port(ch_port), .ch_payload(ch_payload),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_port(ch_rsp_port), .ch_rsp_data(ch_rsp_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_load(cfg_load), .cfg_order(cfg_order),
    .cfg_rotate(cfg_rotate), .prio_order(prio_order)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  int ord [NP];
  logic [NP-1:0] pending = '0;
  logic [NP-1:0] exp_grant;
  logic [NC-1:0] exp_chv;
  int exp_chp [NC];
  logic [PW-1:0] exp_chd [NC];
  logic [NP-1:0] exp_rv;
  logic [RW-1:0] exp_rd [NP];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NP*IW-1:0] pack_ord();
    logic [NP*IW-1:0] v;
    for (int k = 0; k < NP; k++) v[k*IW +: IW] = IW'(ord[k]);
    return v;
  endfunction

  function automatic bit is_perm(input logic [NP*IW-1:0] v);
    logic [NP-1:0] s;
    s = '0;
    for (int k = 0; k < NP; k++) s[v[k*IW +: IW]] = 1'b1;
    return &s;
  endfunction

  // compute expected grants/channels with the current model order
  task automatic model_arb();
    int n;
    n = 0;
    exp_grant = '0;
    exp_chv = '0;
    for (int s = 0; s < NP; s++) begin
      if (req_valid[ord[s]] && n < NC) begin
        exp_grant[ord[s]] = 1'b1;
        exp_chv[n] = 1'b1;
        exp_chp[n] = ord[s];
        exp_chd[n] = req_payload[ord[s]*PW +: PW];
        n++;
      end
    end
  endtask

  task automatic model_cfg();
    if (cfg_load) begin
      if (is_perm(cfg_order)) for (int k = 0; k < NP; k++) ord[k] = int'(cfg_order[k*IW +: IW]);
    end else if (cfg_rotate) begin
      int last;
      last = ord[NP-1];
      for (int k = NP - 1; k > 0; k--) ord[k] = ord[k-1];
      ord[0] = last;
    end
  endtask

  task automatic model_rsp();
    exp_rv = '0;
    for (int c = NC - 1; c >= 0; c--)
      if (ch_rsp_valid[c]) begin
        exp_rv[ch_rsp_port[c*IW +: IW]] = 1'b1;
        exp_rd[ch_rsp_port[c*IW +: IW]] = ch_rsp_data[c*RW +: RW];
      end
  endtask

  // inputs already driven: build expectations, cross the edge, compare
  task automatic cycle(input string tag);
    model_arb();
    model_rsp();
    model_cfg();
    @(negedge clk);
    check({tag, " R2 R4 grant"}, 128'(req_grant), 128'(exp_grant));
    check({tag, " R3 ch_valid"}, 128'(ch_valid), 128'(exp_chv));
    for (int c = 0; c < NC; c++)
      if (exp_chv[c]) begin
        check({tag, " R3 ch_port"}, 128'(ch_port[c*IW +: IW]), 128'(exp_chp[c]));
        check({tag, " R3 ch_payload"}, 128'(ch_payload[c*PW +: PW]), 128'(exp_chd[c]));
      end
    check({tag, " R5 R6 R7 R8 order"}, 128'(prio_order), 128'(pack_ord()));
    check({tag, " R9 rsp_valid"}, 128'(rsp_valid), 128'(exp_rv));
    for (int p = 0; p < NP; p++)
      if (exp_rv[p]) check({tag, " R9 rsp_data"}, 128'(rsp_data[p*RW +: RW]), 128'(exp_rd[p]));
  endtask

  task automatic idle_inputs();
    cfg_load = 0; cfg_rotate = 0; ch_rsp_valid = '0;
  endtask

  // drive requests: keep losers raised, add new requesters with fresh payloads
  task automatic drive_req(input logic [NP-1:0] fresh);
    logic [NP-1:0] nr;
    nr = pending | fresh;
    for (int p = 0; p < NP; p++)
      if (nr[p] && !pending[p]) req_payload[p*PW +: PW] = PW'($urandom);
    req_valid = nr;
  endtask

  task automatic after_cycle();
    pending = req_valid & ~exp_grant;
  endtask

  initial begin
    logic [NP*IW-1:0] perm;
    void'($urandom(32'd1234));
    for (int k = 0; k < NP; k++) ord[k] = k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 grant", 128'(req_grant), 128'(0));
    check("R1 ch_valid", 128'(ch_valid), 128'(0));
    check("R1 rsp_valid", 128'(rsp_valid), 128'(0));
    check("R1 order", 128'(prio_order), 128'(pack_ord()));
    rst = 0;

    // R4: all ports request, held until granted; each granted exactly once
    drive_req('1);
    for (int i = 0; i < NP / NC; i++) begin
      cycle("dir-all");
      after_cycle();
      drive_req('0);
    end
    check("R4 all served", 128'(pending), 128'(0));
    req_valid = '0;

    // R4: fewer requesters than channels, lowest priority port alone
    req_valid = 8'h80; req_payload[7*PW +: PW] = 16'hBEEF;
    cycle("dir-single R4");
    req_valid = '0;

    // R6: duplicate id load ignored
    cfg_load = 1; cfg_order = pack_ord(); cfg_order[IW-1:0] = cfg_order[2*IW-1:IW];
    cycle("dir-dup R6");
    // R8: valid load with rotate in the same cycle
    for (int k = 0; k < NP; k++) perm[k*IW +: IW] = IW'(NP - 1 - k);
    cfg_load = 1; cfg_rotate = 1; cfg_order = perm;
    cycle("dir-load+rot R8");
    // R8: bad load with rotate, rotate still dropped
    cfg_order[IW-1:0] = cfg_order[2*IW-1:IW];
    cycle("dir-badload+rot R8");
    idle_inputs();
    // R7: NP rotates restore the order
    for (int i = 0; i < NP; i++) begin cfg_rotate = 1; cycle("dir-rot R7"); end
    cfg_rotate = 0;
    // R5: load takes effect after the edge, arbitration uses old order
    req_valid = 8'h03;
    for (int k = 0; k < NP; k++) perm[k*IW +: IW] = IW'(NP - 1 - k);
    perm[0 +: IW] = 3'd1; perm[(NP-2)*IW +: IW] = 3'd7; // slot0=1, slot6=7
    cfg_load = 1; cfg_order = perm;
    cycle("dir-load R5");
    cfg_load = 0;
    req_valid = 8'h83;
    cycle("dir-neworder R5");
    req_valid = '0;
    // R9: two channels return to the same port, channel 0 kept
    ch_rsp_valid = 2'b11; ch_rsp_port = {3'd4, 3'd4}; ch_rsp_data = {16'h2222, 16'h1111};
    cycle("dir-clash R9");
    idle_inputs();
    pending = '0;

    // constrained random
    for (int i = 0; i < 400; i++) begin
      drive_req(NP'($urandom));
      ch_rsp_valid = NC'($urandom);
      ch_rsp_port = (NC*IW)'($urandom);
      ch_rsp_data = (NC*RW)'($urandom);
      cfg_load = 0; cfg_rotate = 0;
      case ($urandom_range(0, 9))
        0: begin
          for (int k = 0; k < NP; k++) ord[k] = ord[k];
          perm = pack_ord();
          for (int k = NP - 1; k > 0; k--) begin
            int j; logic [IW-1:0] t;
            j = $urandom_range(0, k);
            t = perm[k*IW +: IW]; perm[k*IW +: IW] = perm[j*IW +: IW]; perm[j*IW +: IW] = t;
          end
          cfg_load = 1; cfg_order = perm;
        end
        1: begin cfg_load = 1; cfg_order = (NP*IW)'($urandom); cfg_rotate = $urandom_range(0, 1); end
        2, 3: cfg_rotate = 1;
        default: ;
      endcase
      cycle("rand");
      after_cycle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule